// File: doc/BRIEF.md
# Four-Operator Connection Router

This block decides, for every operator slot of an FM synthesizer with two banks of nine channels and eighteen operators per bank, which other operator (if any) feeds its phase modulation input. Each channel normally drives two operators, one after the other. Under an extended mode, one of six pairing bits can join two channels into one four-operator voice. The algorithm bits of the two joined channels then pick one of four serial or parallel arrangements of the four operators.

The router is purely a configuration path. It takes the per-channel algorithm bits, the pairing bits and the extended-mode flag. It delivers one source code per operator: a valid flag and a six-bit operator index. The operator engine reads these codes when it fetches modulation inputs. The outputs are recomputed continuously and registered, so any change at the inputs shows at the outputs one clock later.

Top module: `four_op_router`

## Requirements
- R1: While `rst` is high at a rising edge, every `mod_valid_o` bit and every `mod_index_o` field reads 0 after that edge, whatever the other inputs are.
- R2: An operator with no modulation source is reported as valid 0 with index 0. The first operator of a channel that is not part of a four-operator voice never has a source.
- R3: In two-operator operation, the second operator of a channel takes the first operator of the same channel as its source when that channel's algorithm bit is 0. It has no source when the bit is 1.
- R4: A pair is joined only when `ext_mode_i` is 1 and its pairing bit is 1. If either is 0, both channels of the pair behave as R2/R3 describe.
- R5: Pairing bit k (k = 0..2) joins bank-0 channels k and k+3. Bit k (k = 3..5) joins bank-1 channels k+6 and k+9. Each bit affects only its own two channels.
- R6: In a joined voice, the four operators are op1..op4, and the selector is {algorithm of the lower channel, algorithm of the upper channel}. Selector 0 chains op1 into op2, op2 into op3 and op3 into op4.
- R7: Selector 1 gives op2 the source op1 and op4 the source op3. op3 has no source.
- R8: Selector 2 leaves op2 without a source. op3 takes op2 and op4 takes op3.
- R9: Selector 3 leaves op2 and op4 without a source. op3 takes op2.
- R10: Channels at offsets 6 to 8 of each bank always use two-operator operation, regardless of the pairing bits and the mode flag.
- R11: An input change is visible at the outputs exactly one clock edge later. With stable inputs, the outputs do not change.
- R12: Clearing a pairing bit returns both channels of that pair to independent two-operator operation on the next edge.
- R13: Channel offset o of bank b has its first operator at index 18*b + o, +3 more when o is 3..5, +6 more when o is 6..8. The second operator is 3 above the first. In a joined voice, op1 and op2 belong to the lower channel and op3 and op4 to the upper one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode_i | input | 1 | Extended mode flag that permits four-operator voices |
| quad_en_i | input | 6 | Pairing bits, one per joinable channel pair |
| alg_i | input | 18 | Algorithm bit per channel, channel index 9*bank + offset |
| mod_valid_o | output | 36 | Per operator: 1 when a modulation source exists |
| mod_index_o | output | 216 | Per operator: 6-bit source operator index, operator i at bits 6*i+5..6*i |

## Verification
The bench builds the router with its default of two banks. This puts the second bank's operators 18 to 35 and pairing bits 3 to 5 within reach, so the mapping of the upper pairing bits to channels 9 to 11 can be tested against the lower ones. Directed scenarios cover each of the four joined topologies, mode-off and bit-off fallbacks, and the unpaired channels at offsets 6 to 8. A pseudo-random sweep compares all 36 source codes against a reference model. That model is written operator by operator, from the numbering rule rather than from channels.

// File: rtl/fm_route_pkg.sv
package fm_route_pkg;

    localparam int OPS_PER_BANK   = 18;
    localparam int CH_PER_BANK    = 9;
    localparam int PAIRS_PER_BANK = 3;
    localparam int IDX_W          = 6;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } mod_src_t;

    // selector = {lower channel algorithm, upper channel algorithm}
    typedef enum logic [1:0] {
        TOPO_CHAIN      = 2'd0,
        TOPO_SPLIT_MID  = 2'd1,
        TOPO_SPLIT_HEAD = 2'd2,
        TOPO_TWIN       = 2'd3
    } topo_e;

    localparam mod_src_t SRC_NONE = '{valid: 1'b0, idx: '0};

    function automatic mod_src_t src_from(input int op);
        return '{valid: 1'b1, idx: IDX_W'(op)};
    endfunction

    // R13: first operator slot of a channel
    function automatic logic [IDX_W-1:0] chan_first_op(input int bank, input int off);
        int r;
        r = off;
        if (off >= 6)      r = r + 6;
        else if (off >= 3) r = r + 3;
        return IDX_W'(r + bank * OPS_PER_BANK);
    endfunction

endpackage

// File: rtl/pair_router.sv
module pair_router
    import fm_route_pkg::*;
#(
    parameter int BANK = 0,
    parameter int PAIR = 0
) (
    input  logic     ext_mode,
    input  logic     pair_en,
    input  logic     alg_lo,
    input  logic     alg_hi,
    output mod_src_t src_q1,
    output mod_src_t src_q2,
    output mod_src_t src_q3,
    output mod_src_t src_q4
);
    localparam int OP1 = int'(chan_first_op(BANK, PAIR));
    localparam int OP2 = OP1 + 3;
    localparam int OP3 = int'(chan_first_op(BANK, PAIR + 3));

    logic  joined;
    topo_e topo;

    assign joined = ext_mode & pair_en;
    assign topo   = topo_e'({alg_lo, alg_hi});

    always_comb begin
        src_q1 = SRC_NONE;
        src_q2 = SRC_NONE;
        src_q3 = SRC_NONE;
        src_q4 = SRC_NONE;
        if (joined) begin
            unique case (topo)
                TOPO_CHAIN: begin
                    src_q2 = src_from(OP1);
                    src_q3 = src_from(OP2);
                    src_q4 = src_from(OP3);
                end
                TOPO_SPLIT_MID: begin
                    src_q2 = src_from(OP1);
                    src_q4 = src_from(OP3);
                end
                TOPO_SPLIT_HEAD: begin
                    src_q3 = src_from(OP2);
                    src_q4 = src_from(OP3);
                end
                TOPO_TWIN: begin
                    src_q3 = src_from(OP2);
                end
                default: ;
            endcase
        end else begin
            src_q2 = alg_lo ? SRC_NONE : src_from(OP1);
            src_q4 = alg_hi ? SRC_NONE : src_from(OP3);
        end
    end
endmodule

// File: rtl/solo_router.sv
module solo_router
    import fm_route_pkg::*;
#(
    parameter int BANK = 0,
    parameter int OFF  = 6
) (
    input  logic     alg,
    output mod_src_t src_first,
    output mod_src_t src_second
);
    localparam int FIRST = int'(chan_first_op(BANK, OFF));

    assign src_first  = SRC_NONE;
    assign src_second = alg ? SRC_NONE : src_from(FIRST);
endmodule

// File: rtl/route_regs.sv
module route_regs
    import fm_route_pkg::*;
#(
    parameter int N = 36
) (
    input  logic     clk,
    input  logic     rst,
    input  mod_src_t nxt [N],
    output mod_src_t cur [N]
);
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) cur[i] <= SRC_NONE;
            else     cur[i] <= nxt[i];
        end
    end
endmodule

// File: rtl/four_op_router.sv
module four_op_router
    import fm_route_pkg::*;
#(
    parameter  int NUM_BANKS = 2,
    localparam int NUM_CH    = CH_PER_BANK * NUM_BANKS,
    localparam int NUM_OPS   = OPS_PER_BANK * NUM_BANKS,
    localparam int NUM_PAIRS = PAIRS_PER_BANK * NUM_BANKS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ext_mode_i,
    input  logic [NUM_PAIRS-1:0]     quad_en_i,
    input  logic [NUM_CH-1:0]        alg_i,
    output logic [NUM_OPS-1:0]       mod_valid_o,
    output logic [NUM_OPS*IDX_W-1:0] mod_index_o
);
    mod_src_t next_src [NUM_OPS];
    mod_src_t cur_src  [NUM_OPS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar p = 0; p < PAIRS_PER_BANK; p++) begin : g_pair
            localparam int LO = int'(chan_first_op(b, p));
            localparam int HI = int'(chan_first_op(b, p + 3));
            mod_src_t q1, q2, q3, q4;

            pair_router #(.BANK(b), .PAIR(p)) u_pair (
                .ext_mode (ext_mode_i),
                .pair_en  (quad_en_i[b*PAIRS_PER_BANK + p]),
                .alg_lo   (alg_i[b*CH_PER_BANK + p]),
                .alg_hi   (alg_i[b*CH_PER_BANK + p + 3]),
                .src_q1   (q1),
                .src_q2   (q2),
                .src_q3   (q3),
                .src_q4   (q4)
            );

            assign next_src[LO]     = q1;
            assign next_src[LO + 3] = q2;
            assign next_src[HI]     = q3;
            assign next_src[HI + 3] = q4;
        end

        for (genvar o = 2 * PAIRS_PER_BANK; o < CH_PER_BANK; o++) begin : g_solo
            localparam int F = int'(chan_first_op(b, o));
            mod_src_t s1, s2;

            solo_router #(.BANK(b), .OFF(o)) u_solo (
                .alg        (alg_i[b*CH_PER_BANK + o]),
                .src_first  (s1),
                .src_second (s2)
            );

            assign next_src[F]     = s1;
            assign next_src[F + 3] = s2;
        end
    end

    route_regs #(.N(NUM_OPS)) u_regs (
        .clk (clk),
        .rst (rst),
        .nxt (next_src),
        .cur (cur_src)
    );

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_out
        assign mod_valid_o[i]                 = cur_src[i].valid;
        assign mod_index_o[i*IDX_W +: IDX_W]  = cur_src[i].idx;
    end
endmodule

// File: rtl/route_checker.sv
module route_checker
    import fm_route_pkg::*;
#(
    parameter  int NUM_BANKS = 2,
    localparam int NUM_CH    = CH_PER_BANK * NUM_BANKS,
    localparam int NUM_OPS   = OPS_PER_BANK * NUM_BANKS,
    localparam int NUM_PAIRS = PAIRS_PER_BANK * NUM_BANKS
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     ext_mode_i,
    input logic [NUM_PAIRS-1:0]     quad_en_i,
    input logic [NUM_CH-1:0]        alg_i,
    input logic [NUM_OPS-1:0]       mod_valid_o,
    input logic [NUM_OPS*IDX_W-1:0] mod_index_o
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (mod_valid_o == '0 && mod_index_o == '0));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(alg_i) && $stable(quad_en_i) && $stable(ext_mode_i))
        |=> ($stable(mod_valid_o) && $stable(mod_index_o)));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
        for (genvar o = 0; o < CH_PER_BANK; o++) begin : g_ch
            localparam int F = int'(chan_first_op(b, o));
            localparam int C = b * CH_PER_BANK + o;

            if (o < PAIRS_PER_BANK) begin : g_lower
                p_first_none_r2: assert property (@(posedge clk) disable iff (rst)
                    1'b1 |=> (!mod_valid_o[F] && mod_index_o[F*IDX_W +: IDX_W] == '0));
            end

            p_twoop_second_r3: assert property (@(posedge clk) disable iff (rst)
                !ext_mode_i |=> (mod_valid_o[F+3] == !$past(alg_i[C])));

            p_twoop_index_r3: assert property (@(posedge clk) disable iff (rst)
                (!ext_mode_i && !alg_i[C]) |=> (mod_index_o[(F+3)*IDX_W +: IDX_W] == IDX_W'(F)));
        end

        for (genvar p = 0; p < PAIRS_PER_BANK; p++) begin : g_p
            localparam int O1 = int'(chan_first_op(b, p));
            localparam int O3 = int'(chan_first_op(b, p + 3));
            localparam int CL = b * CH_PER_BANK + p;
            localparam int E  = b * PAIRS_PER_BANK + p;

            p_mode_off_r4: assert property (@(posedge clk) disable iff (rst)
                !ext_mode_i |=> !mod_valid_o[O3]);

            p_chain_r6: assert property (@(posedge clk) disable iff (rst)
                (ext_mode_i && quad_en_i[E] && !alg_i[CL] && !alg_i[CL+3])
                |=> (mod_valid_o[O3] && mod_index_o[O3*IDX_W +: IDX_W] == IDX_W'(O1 + 3)
                     && mod_index_o[(O3+3)*IDX_W +: IDX_W] == IDX_W'(O3)));

            p_twin_r9: assert property (@(posedge clk) disable iff (rst)
                (ext_mode_i && quad_en_i[E] && alg_i[CL] && alg_i[CL+3])
                |=> (!mod_valid_o[O1+3] && !mod_valid_o[O3+3] && mod_valid_o[O3]));
        end
    end
endmodule

bind four_op_router route_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ext_mode_i  (ext_mode_i),
    .quad_en_i   (quad_en_i),
    .alg_i       (alg_i),
    .mod_valid_o (mod_valid_o),
    .mod_index_o (mod_index_o)
);

// File: tb/sim_four_op_router.sv
`timescale 1ns/1ps
module sim_four_op_router;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ext_mode_i = 1'b0;
    logic [5:0]   quad_en_i = '0;
    logic [17:0]  alg_i = '0;
    logic [35:0]  mod_valid_o;
    logic [215:0] mod_index_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    four_op_router u0 (
        .clk (clk), .rst (rst), .ext_mode_i (ext_mode_i), .quad_en_i (quad_en_i),
        .alg_i (alg_i), .mod_valid_o (mod_valid_o), .mod_index_o (mod_index_o)
    );

    // expected {valid, index} for one operator, worked out operator by operator
    function automatic logic [6:0] expect_src(input logic ext, input logic [5:0] en,
                                              input logic [17:0] alg, input int op);
        int bank, r, grp, lane, off, ch, base;
        logic [1:0] sel;
        bank = op / 18; r = op % 18; grp = r / 3; lane = r % 3;
        off  = lane + 3 * (grp / 2);
        ch   = bank * 9 + off;
        base = bank * 18 + lane;
        if (ext && en[bank*3 + lane] && grp < 4) begin
            sel = {alg[bank*9 + lane], alg[bank*9 + lane + 3]};
            case (grp)
                1: return (sel < 2)    ? {1'b1, 6'(base)}     : 7'd0;
                2: return (sel != 1)   ? {1'b1, 6'(base + 3)} : 7'd0;
                3: return (sel != 3)   ? {1'b1, 6'(base + 6)} : 7'd0;
                default: return 7'd0;
            endcase
        end
        if (grp % 2 == 0) return 7'd0;
        return alg[ch] ? 7'd0 : {1'b1, 6'(op - 3)};
    endfunction

    task automatic chk(input string req, input int op, input logic v, input int idx);
        logic [6:0] got, exp;
        got = {mod_valid_o[op], mod_index_o[op*6 +: 6]};
        exp = {v, 6'(idx)};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s op%0d: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
                     req, op, got[6], got[5:0], exp[6], exp[5:0]);
        end
    endtask

    task automatic apply(input logic ext, input logic [5:0] en, input logic [17:0] alg);
        @(negedge clk);
        ext_mode_i = ext; quad_en_i = en; alg_i = alg;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        ext_mode_i = 1'b1; quad_en_i = 6'h3F; alg_i = 18'h2A5A5;
        @(negedge clk); @(negedge clk);
        total++;
        if (mod_valid_o !== '0 || mod_index_o !== '0) begin
            bad++;
            $display("FAIL R1 reset: got valid=%h, expected 0", mod_valid_o);
        end
        rst = 1'b0;
    endtask

    task automatic t_two_op;
        apply(1'b0, 6'h00, 18'h0);
        chk("R2", 0, 0, 0);   chk("R3", 3, 1, 0);
        chk("R13", 7, 0, 0);  chk("R13", 10, 1, 7);
        chk("R13", 17, 1, 14); chk("R13", 28, 1, 25);
        apply(1'b0, 6'h00, 18'h3FFFF);
        chk("R3", 3, 0, 0);   chk("R3", 35, 0, 0);  chk("R2", 32, 0, 0);
    endtask

    task automatic t_mode_gate;
        apply(1'b0, 6'h3F, 18'h0);
        chk("R4 mode off", 6, 0, 0); chk("R4 mode off", 9, 1, 6);
        apply(1'b1, 6'h00, 18'h0);
        chk("R4 bit off", 6, 0, 0);  chk("R4 bit off", 3, 1, 0);
    endtask

    task automatic t_topologies;
        apply(1'b1, 6'h01, 18'h0);
        chk("R6", 0, 0, 0); chk("R6", 3, 1, 0); chk("R6", 6, 1, 3); chk("R6", 9, 1, 6);
        chk("R5 neighbour", 7, 0, 0); chk("R5 neighbour", 10, 1, 7);
        apply(1'b1, 6'h01, 18'h00008);
        chk("R7", 3, 1, 0); chk("R7", 6, 0, 0); chk("R7", 9, 1, 6);
        apply(1'b1, 6'h01, 18'h00001);
        chk("R8", 3, 0, 0); chk("R8", 6, 1, 3); chk("R8", 9, 1, 6);
        apply(1'b1, 6'h01, 18'h00009);
        chk("R9", 3, 0, 0); chk("R9", 6, 1, 3); chk("R9", 9, 0, 0);
    endtask

    task automatic t_bit_map;
        apply(1'b1, 6'h08, 18'h0);
        chk("R5 bit3", 24, 1, 21); chk("R5 bit3", 27, 1, 24); chk("R5 bit3", 6, 0, 0);
        apply(1'b1, 6'h24, 18'h0);
        chk("R5 bit5", 26, 1, 23); chk("R5 bit2", 8, 1, 5); chk("R5 bit2", 7, 0, 0);
    endtask

    task automatic t_solo;
        apply(1'b1, 6'h3F, 18'h0);
        chk("R10", 12, 0, 0); chk("R10", 15, 1, 12); chk("R10", 35, 1, 32);
        apply(1'b1, 6'h3F, 18'h3FFFF);
        chk("R10", 15, 0, 0);
    endtask

    task automatic t_release;
        apply(1'b1, 6'h01, 18'h00001);
        chk("R12 joined", 6, 1, 3);
        apply(1'b1, 6'h00, 18'h00001);
        chk("R12", 3, 0, 0); chk("R12", 6, 0, 0); chk("R12", 9, 1, 6);
    endtask

    task automatic t_latency;
        apply(1'b0, 6'h00, 18'h0);
        @(negedge clk);
        alg_i = 18'h00001;
        #1;
        chk("R11 before edge", 3, 1, 0);
        @(negedge clk);
        chk("R11 after edge", 3, 0, 0);
        @(negedge clk);
        chk("R11 hold", 3, 0, 0);
    endtask

    task automatic t_sweep;
        logic [31:0] s;
        s = 32'h1234_5678;
        for (int n = 0; n < 48; n++) begin
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            apply(s[0], s[6:1], s[24:7]);
            for (int op = 0; op < 36; op++) begin
                logic [6:0] e;
                e = expect_src(s[0], s[6:1], s[24:7], op);
                chk("R13 sweep", op, e[6], int'(e[5:0]));
            end
        end
    endtask

    initial begin
        t_reset();
        t_two_op();
        t_mode_gate();
        t_topologies();
        t_bit_map();
        t_solo();
        t_release();
        t_latency();
        t_sweep();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule